// File: doc/BRIEF.md
# Registered Parity Bus Transceiver

This block sits between two 18-bit ports, called A and B, and carries data in both directions at once. Each port is split into two 9-bit lanes. Bits 7:0 of a lane are data and bit 8 is parity. Lane 0 occupies bits 8:0 and lane 1 occupies bits 17:9.

Each direction has its own store, and that store can be transparent, latched or clocked. On the outgoing side, the block either passes every lane through unchanged or replaces the parity bit with freshly generated parity. On the incoming side, it checks each stored lane against the selected parity sense. Each side raises its own active-low error flag.

The pads are outside the block. Each port appears as an input bus, an output bus and an output-enable signal, and the enable is left for the pad ring to use.

Top module: `parity_xcvr`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every stored lane of that direction to zero and deasserts that side's error flag (error flag reads 1).
- R2: When a direction's latch enable is 1, its output data follows its input bus in the same cycle, with no clock edge needed.
- R3: When latch enable is 0, a lane loads its input at a rising edge of that direction's clock only if its active-low clock enable bit (bit k for lane k) is 0. The output then shows the stored value.
- R4: When latch enable is 0 and a lane's clock enable bit is 1, that lane keeps its stored value across clock edges, whatever its input does.
- R5: The two lanes of a direction load independently, each under its own clock-enable bit.
- R6: When `par_bypass` is 1, all 9 bits of every lane, parity included, reach the output unchanged.
- R7: When `par_bypass` is 0, bit 8 of each outgoing lane is replaced. The new value makes the lane's 9-bit count of ones odd when `odd_sel` is 1 and even when `odd_sel` is 0.
- R8: With `par_bypass` 0, a side's error flag is registered on that direction's clock. One edge after a cycle in which either stored lane (A-to-B store for `err_a_n`, B-to-A store for `err_b_n`) fails the selected sense, the flag reads 0. Otherwise it reads 1.
- R9: Within one edge of `par_bypass` being 1, both error flags read 1, whatever the lane contents.
- R10: `b_out_en` equals `drive_b` and `a_out_en` equals `drive_a` in every cycle.
- R11: The B-to-A direction behaves as R2 to R8 describe, under its own clock, latch enable and clock enables, and is unaffected by the A-to-B controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Clock of the A-to-B store and the A-side error flag |
| clk_ba | input | 1 | Clock of the B-to-A store and the B-side error flag |
| rst | input | 1 | Synchronous reset, active high, sampled on both clocks |
| a_in | input | 18 | Data arriving from port A |
| b_in | input | 18 | Data arriving from port B |
| le_ab | input | 1 | A-to-B latch enable, 1 = transparent |
| le_ba | input | 1 | B-to-A latch enable, 1 = transparent |
| cen_ab_n | input | 2 | A-to-B per-lane clock enables, active low |
| cen_ba_n | input | 2 | B-to-A per-lane clock enables, active low |
| par_bypass | input | 1 | 1 = plain feed-through, 0 = parity generate and check |
| odd_sel | input | 1 | Parity sense: 1 = odd, 0 = even |
| drive_b | input | 1 | Request to drive port B |
| drive_a | input | 1 | Request to drive port A |
| b_out | output | 18 | Data presented to port B |
| b_out_en | output | 1 | Output enable for port B |
| a_out | output | 18 | Data presented to port A |
| a_out_en | output | 1 | Output enable for port A |
| err_a_n | output | 1 | Parity error on data received from A, active low |
| err_b_n | output | 1 | Parity error on data received from B, active low |

## Verification
The data paths are first driven with transparent traffic and then with loads, holds and split-lane loads. A lost or swapped clock-enable bit therefore shows up as a mismatch on exactly one lane. Parity is exercised with random bytes under both senses and in bypass, which separates a replaced parity bit from a passed one and an odd sense from an even one. The error flags see random parity on both sides with the two directions' controls set differently. This exposes a flag wired to the wrong store or one that is not registered.

// File: rtl/pxcvr_pkg.sv
package pxcvr_pkg;
   typedef enum logic {
      SENSE_EVEN = 1'b0,
      SENSE_ODD  = 1'b1
   } sense_e;

   localparam int unsigned PAR_BITS = 1;
endpackage

// File: rtl/pxcvr_lane.sv
module pxcvr_lane #(
   parameter int unsigned W = 9
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         le,
   input  logic         cen_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] view
);
   logic [W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (rst)
         held_q <= '0;
      else if (le || !cen_n)
         held_q <= d;
   end

   assign view = le ? d : held_q;
endmodule

// File: rtl/pxcvr_path.sv
module pxcvr_path
   import pxcvr_pkg::*;
#(
   parameter int unsigned LANES  = 2,
   parameter int unsigned DATA_W = 8
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            le,
   input  logic [LANES-1:0]                cen_n,
   input  logic [LANES*(DATA_W+PAR_BITS)-1:0] din,
   input  logic                            bypass,
   input  sense_e                          sense,
   output logic [LANES*(DATA_W+PAR_BITS)-1:0] dout,
   output logic                            err_n
);
   localparam int unsigned LW = DATA_W + PAR_BITS;

   logic [LANES*LW-1:0] view;
   logic [LANES-1:0]    bad;
   logic                err_q;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      pxcvr_lane #(.W(LW)) u_lane (
         .clk   (clk),
         .rst   (rst),
         .le    (le),
         .cen_n (cen_n[k]),
         .d     (din[k*LW +: LW]),
         .view  (view[k*LW +: LW])
      );

      logic gen_bit;
      assign gen_bit = (^view[k*LW +: DATA_W]) ^ logic'(sense);
      assign bad[k]  = (^view[k*LW +: LW]) != logic'(sense);

      assign dout[k*LW +: DATA_W] = view[k*LW +: DATA_W];
      assign dout[k*LW + DATA_W]  = bypass ? view[k*LW + DATA_W] : gen_bit;
   end

   always_ff @(posedge clk) begin
      if (rst)
         err_q <= 1'b0;
      else
         err_q <= !bypass && (|bad);
   end

   assign err_n = !err_q;
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
   import pxcvr_pkg::*;
#(
   parameter int unsigned LANES  = 2,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned BW    = LANES * (DATA_W + 1)
) (
   input  logic             clk_ab,
   input  logic             clk_ba,
   input  logic             rst,
   input  logic [BW-1:0]    a_in,
   input  logic [BW-1:0]    b_in,
   input  logic             le_ab,
   input  logic             le_ba,
   input  logic [LANES-1:0] cen_ab_n,
   input  logic [LANES-1:0] cen_ba_n,
   input  logic             par_bypass,
   input  logic             odd_sel,
   input  logic             drive_b,
   input  logic             drive_a,
   output logic [BW-1:0]    b_out,
   output logic             b_out_en,
   output logic [BW-1:0]    a_out,
   output logic             a_out_en,
   output logic             err_a_n,
   output logic             err_b_n
);
   if (LANES < 1) begin : g_bad_lanes
      $error("parity_xcvr: LANES must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("parity_xcvr: DATA_W must be at least 1");
   end

   sense_e sense;
   assign sense = sense_e'(odd_sel);

   pxcvr_path #(.LANES(LANES), .DATA_W(DATA_W)) u_ab (
      .clk    (clk_ab),
      .rst    (rst),
      .le     (le_ab),
      .cen_n  (cen_ab_n),
      .din    (a_in),
      .bypass (par_bypass),
      .sense  (sense),
      .dout   (b_out),
      .err_n  (err_a_n)
   );

   pxcvr_path #(.LANES(LANES), .DATA_W(DATA_W)) u_ba (
      .clk    (clk_ba),
      .rst    (rst),
      .le     (le_ba),
      .cen_n  (cen_ba_n),
      .din    (b_in),
      .bypass (par_bypass),
      .sense  (sense),
      .dout   (a_out),
      .err_n  (err_b_n)
   );

   assign b_out_en = drive_b;
   assign a_out_en = drive_a;
endmodule

// File: rtl/pxcvr_chk.sv
module pxcvr_chk #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned LW    = DATA_W + 1,
   localparam int unsigned BW    = LANES * LW
) (
   input logic             clk_ab,
   input logic             clk_ba,
   input logic             rst,
   input logic [BW-1:0]    a_in,
   input logic             le_ab,
   input logic [LANES-1:0] cen_ab_n,
   input logic             par_bypass,
   input logic             odd_sel,
   input logic             drive_b,
   input logic [BW-1:0]    b_out,
   input logic             b_out_en,
   input logic [BW-1:0]    a_out,
   input logic             err_a_n,
   input logic             err_b_n
);
   function automatic logic all_lanes_sense(input logic [BW-1:0] v, input logic s);
      logic ok;
      ok = 1'b1;
      for (int k = 0; k < int'(LANES); k++)
         if ((^v[k*LW +: LW]) != s) ok = 1'b0;
      return ok;
   endfunction

   // R2
   transparent_pass_chk: assert property (@(posedge clk_ab) disable iff (rst)
      (le_ab && par_bypass) |-> (b_out == a_in));

   // R4
   hold_stable_chk: assert property (@(posedge clk_ab) disable iff (rst)
      (!le_ab && (&cen_ab_n) && par_bypass) |=> (le_ab || !par_bypass || $stable(b_out)));

   // R7
   gen_sense_b_chk: assert property (@(posedge clk_ab) disable iff (rst)
      !par_bypass |-> all_lanes_sense(b_out, odd_sel));

   // R11
   gen_sense_a_chk: assert property (@(posedge clk_ba) disable iff (rst)
      !par_bypass |-> all_lanes_sense(a_out, odd_sel));

   // R9
   bypass_err_a_chk: assert property (@(posedge clk_ab) disable iff (rst)
      par_bypass |=> err_a_n);

   // R9
   bypass_err_b_chk: assert property (@(posedge clk_ba) disable iff (rst)
      par_bypass |=> err_b_n);

   // R10
   enable_follow_chk: assert property (@(posedge clk_ab) disable iff (rst)
      drive_b |-> b_out_en);
endmodule

bind parity_xcvr pxcvr_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
   .clk_ab     (clk_ab),
   .clk_ba     (clk_ba),
   .rst        (rst),
   .a_in       (a_in),
   .le_ab      (le_ab),
   .cen_ab_n   (cen_ab_n),
   .par_bypass (par_bypass),
   .odd_sel    (odd_sel),
   .drive_b    (drive_b),
   .b_out      (b_out),
   .b_out_en   (b_out_en),
   .a_out      (a_out),
   .err_a_n    (err_a_n),
   .err_b_n    (err_b_n)
);

// File: tb/parity_xcvr_test.sv
`timescale 1ns/1ps
module parity_xcvr_test;
   logic        clk = 1'b0;
   logic        rst;
   logic [17:0] a_in, b_in;
   logic        le_ab, le_ba;
   logic [1:0]  cen_ab_n, cen_ba_n;
   logic        par_bypass, odd_sel, drive_b, drive_a;
   logic [17:0] b_out, a_out;
   logic        b_out_en, a_out_en, err_a_n, err_b_n;

   always #2.5 clk = ~clk;

   parity_xcvr uut (
      .clk_ab(clk), .clk_ba(clk), .rst(rst),
      .a_in(a_in), .b_in(b_in), .le_ab(le_ab), .le_ba(le_ba),
      .cen_ab_n(cen_ab_n), .cen_ba_n(cen_ba_n),
      .par_bypass(par_bypass), .odd_sel(odd_sel),
      .drive_b(drive_b), .drive_a(drive_a),
      .b_out(b_out), .b_out_en(b_out_en), .a_out(a_out), .a_out_en(a_out_en),
      .err_a_n(err_a_n), .err_b_n(err_b_n)
   );

   // behavioural reference state
   logic [8:0] mq_ab [2];
   logic [8:0] mq_ba [2];
   bit         merr_a, merr_b;
   int         vectors = 0, fails = 0;
   string      cur_req = "R2";
   bit         cmp_on = 0;

   function automatic logic [17:0] mview(input logic [17:0] din, input logic le,
                                         input logic [8:0] q0, input logic [8:0] q1);
      return le ? din : {q1, q0};
   endfunction

   function automatic logic [17:0] mout(input logic [17:0] v);
      logic [17:0] r;
      r = v;
      if (!par_bypass)
         for (int k = 0; k < 2; k++) begin
            int ones = 0;
            for (int i = 0; i < 8; i++) ones += v[k*9+i];
            r[k*9+8] = ((ones % 2) == 1) ? ~odd_sel : odd_sel;
         end
      return r;
   endfunction

   function automatic bit mbad(input logic [17:0] v);
      bit b = 0;
      for (int k = 0; k < 2; k++) begin
         int ones = 0;
         for (int i = 0; i < 9; i++) ones += v[k*9+i];
         if ((ones % 2) != int'(odd_sel)) b = 1;
      end
      return b;
   endfunction

   always @(posedge clk) begin
      logic [17:0] va, vb;
      va = mview(a_in, le_ab, mq_ab[0], mq_ab[1]);
      vb = mview(b_in, le_ba, mq_ba[0], mq_ba[1]);
      if (rst) begin
         mq_ab[0] = '0; mq_ab[1] = '0; mq_ba[0] = '0; mq_ba[1] = '0;
         merr_a = 0; merr_b = 0;
      end else begin
         merr_a = !par_bypass && mbad(va);
         merr_b = !par_bypass && mbad(vb);
         for (int k = 0; k < 2; k++) begin
            if (le_ab || !cen_ab_n[k]) mq_ab[k] = a_in[k*9 +: 9];
            if (le_ba || !cen_ba_n[k]) mq_ba[k] = b_in[k*9 +: 9];
         end
      end
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic compare_all();
      check(cur_req, {14'd0, b_out}, {14'd0, mout(mview(a_in, le_ab, mq_ab[0], mq_ab[1]))});
      check("R11", {14'd0, a_out}, {14'd0, mout(mview(b_in, le_ba, mq_ba[0], mq_ba[1]))});
      check(par_bypass ? "R9" : "R8", {30'd0, err_a_n, err_b_n}, {30'd0, !merr_a, !merr_b});
      check("R10", {30'd0, b_out_en, a_out_en}, {30'd0, drive_b, drive_a});
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (cmp_on) compare_all();
      end
   endtask

   initial begin
      rst = 1; a_in = '1; b_in = '1; le_ab = 0; le_ba = 0;
      cen_ab_n = 2'b00; cen_ba_n = 2'b00; par_bypass = 1; odd_sel = 1;
      drive_b = 0; drive_a = 0;
      step(3);
      // R1: stored lanes zero, flags inactive
      check("R1", {14'd0, b_out}, 32'd0);
      check("R1", {14'd0, a_out}, 32'd0);
      check("R1", {30'd0, err_a_n, err_b_n}, 32'd3);
      rst = 0; cmp_on = 1;

      // R2 / R6: transparent feed-through
      le_ab = 1; le_ba = 1; cur_req = "R2";
      for (int i = 0; i < 20; i++) begin
         a_in = 18'($urandom); b_in = 18'($urandom); step(1);
         check("R6", {14'd0, b_out}, {14'd0, a_in});
      end
      // R3: clocked load
      le_ab = 0; le_ba = 0; cur_req = "R3";
      for (int i = 0; i < 10; i++) begin
         a_in = 18'($urandom); b_in = 18'($urandom); step(1);
      end
      // R4: hold while inputs churn
      cen_ab_n = 2'b11; cen_ba_n = 2'b11; cur_req = "R4";
      for (int i = 0; i < 10; i++) begin
         a_in = 18'($urandom); b_in = 18'($urandom); step(1);
      end
      // R5: lanes load independently
      cur_req = "R5";
      for (int i = 0; i < 20; i++) begin
         cen_ab_n = 2'(i); cen_ba_n = 2'(~i);
         a_in = 18'($urandom); b_in = 18'($urandom); step(1);
      end
      // R7 / R8: parity generation and checking, both senses
      par_bypass = 0; cur_req = "R7";
      for (int i = 0; i < 200; i++) begin
         odd_sel = i[3]; le_ab = i[0]; le_ba = i[1];
         cen_ab_n = 2'($urandom); cen_ba_n = 2'($urandom);
         a_in = 18'($urandom); b_in = 18'($urandom); step(1);
      end
      // R9: bypass silences flags
      par_bypass = 1; cur_req = "R6";
      for (int i = 0; i < 20; i++) begin
         a_in = 18'($urandom); b_in = 18'($urandom); step(1);
      end
      step(1);
      check("R9", {30'd0, err_a_n, err_b_n}, 32'd3);
      // R10 / R11: mixed random traffic on everything
      for (int i = 0; i < 2000; i++) begin
         par_bypass = 1'($urandom); odd_sel = 1'($urandom);
         cur_req = par_bypass ? "R6" : "R7";
         le_ab = 1'($urandom); le_ba = 1'($urandom);
         cen_ab_n = 2'($urandom); cen_ba_n = 2'($urandom);
         drive_a = 1'($urandom); drive_b = 1'($urandom);
         a_in = 18'($urandom); b_in = 18'($urandom);
         rst = ($urandom % 200) == 0;
         step(1);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule